// File: doc/BRIEF.md
# Serial ADC Device-Side Port

This block is a digital model of the converter side of a three-wire serial ADC link. It runs on a fast system clock and treats the convert strobe, the shift clock and the serial data input as asynchronous pins. Each pin passes through a synchroniser before its edges are detected. A rising convert strobe starts a conversion of fixed length, counted in system clock cycles. When the conversion ends, the block takes a 12-bit result from a parallel input that stands in for the analog core. While the strobe stays high after that, the block rests in a sleep state.

Lowering the strobe enables the serial output driver and puts the block in sample mode. The result then leaves MSB first, one bit per falling shift-clock edge, and zeros follow once the result is used up. The transfer is full duplex. During the first two shift-clock rising edges the block receives a 2-bit input-selection word. That word governs the following conversion. The block outputs the positive and negative input selection decoded from it. Analog behaviour, the reference and power are not modelled.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is asleep, not busy and not sampling, the output enable is low, and the active selection is CH0 positive against ground (chan_pos_o=2'b01, chan_neg_o=2'b00).
- R2: A rising edge on conv_i raises busy_o for exactly CONV_CYCLES system clock cycles, beginning within three clock edges of the pin change. busy_o is never high together with sdo_oe_o, sample_o or sleep_o.
- R3: If conv_i is high when the conversion ends, sleep_o goes high and stays high, with sdo_oe_o low, until conv_i falls.
- R4: A falling conv_i out of sleep sets sample_o and sdo_oe_o. The output enable is low at all other times, including the whole time conv_i is high.
- R5: In sample mode sdo_o shows result bit 11 first. Each falling sck_i edge then advances it by one bit toward bit 0.
- R6: Once all 12 result bits have been shown, every further falling sck_i edge in the same sample period leaves sdo_o at 0.
- R7: sdi_i is sampled on the first two rising sck_i edges of a sample period. The first bit is bit 1 of the selection word and the second is bit 0. Later sdi_i values are ignored. A sample period with fewer than two rising edges leaves the stored word unchanged.
- R8: A received word takes effect at the next rising conv_i and not before. The decoding, with bit 0 of the one-hot outputs meaning CH0 and bit 1 meaning CH1 (a neg value of 00 means ground), is: 10 gives pos CH0 and neg ground; 11 gives pos CH1 and neg ground; 00 gives pos CH0 and neg CH1; 01 gives pos CH1 and neg CH0.
- R9: A rising conv_i during a transfer drops the output enable, discards the remaining bits and starts a new conversion. The next transfer carries the new result.
- R10: If conv_i is already low when a conversion ends, the block goes straight to sample mode with the output enabled and result bit 11 on sdo_o.
- R11: The result is captured from core_data_i at the end of the conversion. Changes on core_data_i during the transfer do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert strobe pin, asynchronous |
| sck_i | input | 1 | Shift clock pin, asynchronous |
| sdi_i | input | 1 | Serial selection input pin, asynchronous |
| core_data_i | input | DATA_W | Parallel result from the modelled converter core |
| sdo_o | output | 1 | Serial result bit |
| sdo_oe_o | output | 1 | Output driver enable; low means high impedance |
| busy_o | output | 1 | Conversion in progress |
| sleep_o | output | 1 | Sleeping after a conversion while the strobe is high |
| sample_o | output | 1 | Sample mode, transfer window open |
| chan_pos_o | output | 2 | One-hot positive input of the active selection |
| chan_neg_o | output | 2 | One-hot negative input, zero meaning ground |

## Verification
The bench targets the moment a received word takes effect. A design that applied the word at once would change the selection outputs in the middle of a transfer, before the next conversion starts. Extra SDI toggles after the second clock catch a receiver that keeps shifting and overwrites the word. A one-clock transfer catches a receiver that commits a half-received word. Long runs of extra shift clocks catch a shift register that wraps the result around instead of filling with zeros. A strobe that falls before the conversion ends, a strobe that restarts mid-transfer, and a parallel input that changes after capture catch designs that load the result late, stay on the old result, or never enable the driver.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_CONV   = 2'd1,
    ST_SAMPLE = 2'd2
  } port_state_e;

  // single-ended CH0 after reset
  localparam logic [1:0] SEL_RESET = 2'b10;

  // selection word: bit1 = single-ended flag, bit0 = odd/sign flag
  function automatic logic [1:0] sel_pos(input logic [1:0] sel);
    return sel[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] sel_neg(input logic [1:0] sel);
    if (sel[1]) return 2'b00;
    return sel[0] ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], pin_i};
  end

  assign level_o = chain[STAGES-1];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_port_pkg::*;
#(
  parameter int CONV_CYCLES = 320
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        conv_lvl,
  input  logic        conv_rise,
  input  logic        conv_fall,
  output port_state_e state_o,
  output logic        done_o,
  output logic        enter_sample_o
);
  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  port_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o         = (state_q == ST_CONV) && (cnt_q == LAST) && !conv_rise;
  assign enter_sample_o = (done_o && !conv_lvl) ||
                          ((state_q == ST_SLEEP) && conv_fall && !conv_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SLEEP;
      cnt_q   <= '0;
    end else if (conv_rise) begin
      state_q <= ST_CONV;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_CONV: begin
          if (cnt_q == LAST) state_q <= conv_lvl ? ST_SLEEP : ST_SAMPLE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_SLEEP: if (conv_fall) state_q <= ST_SAMPLE;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/adc_shift_io.sv
module adc_shift_io
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              enter_sample_i,
  input  logic              in_sample_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_lvl_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [1:0]        chan_pos_o,
  output logic [1:0]        chan_neg_o
);
  localparam int RXC_W = $clog2(SEL_W + 1);

  logic [DATA_W-1:0] shreg_q;
  logic [SEL_W-1:0]  rx_q;
  logic [SEL_W-1:0]  pend_q;
  logic [RXC_W-1:0]  rx_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q    <= '0;
      rx_q       <= '0;
      rx_cnt_q   <= '0;
      pend_q     <= SEL_RESET;
      sdo_o      <= 1'b0;
      sdo_oe_o   <= 1'b0;
      chan_pos_o <= sel_pos(SEL_RESET);
      chan_neg_o <= sel_neg(SEL_RESET);
    end else if (start_i) begin
      sdo_o      <= 1'b0;
      sdo_oe_o   <= 1'b0;
      rx_cnt_q   <= '0;
      chan_pos_o <= sel_pos(pend_q);
      chan_neg_o <= sel_neg(pend_q);
    end else begin
      if (load_i) shreg_q <= core_data_i;
      if (enter_sample_i) begin
        sdo_oe_o <= 1'b1;
        sdo_o    <= load_i ? core_data_i[DATA_W-1] : shreg_q[DATA_W-1];
        rx_cnt_q <= '0;
      end else if (in_sample_i) begin
        if (sck_fall_i) begin
          shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
          sdo_o   <= shreg_q[DATA_W-2];
        end
        if (sck_rise_i && (rx_cnt_q < RXC_W'(SEL_W))) begin
          rx_q     <= {rx_q[SEL_W-2:0], sdi_lvl_i};
          rx_cnt_q <= rx_cnt_q + 1'b1;
          if (rx_cnt_q == RXC_W'(SEL_W - 1))
            pend_q <= {rx_q[SEL_W-2:0], sdi_lvl_i};
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SEL_W       = 2,
  parameter int CONV_CYCLES = 320,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              sleep_o,
  output logic              sample_o,
  output logic [1:0]        chan_pos_o,
  output logic [1:0]        chan_neg_o
);
  logic conv_lvl, sck_lvl, sdi_lvl;
  logic conv_d, sck_d;
  logic conv_rise, conv_fall, sck_rise, sck_fall;
  logic done, enter_sample;
  port_state_e state;

  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_conv (.clk(clk), .rst(rst), .pin_i(conv_i), .level_o(conv_lvl));
  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sck  (.clk(clk), .rst(rst), .pin_i(sck_i),  .level_o(sck_lvl));
  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi  (.clk(clk), .rst(rst), .pin_i(sdi_i),  .level_o(sdi_lvl));

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_d <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      conv_d <= conv_lvl;
      sck_d  <= sck_lvl;
    end
  end

  assign conv_rise = conv_lvl & ~conv_d;
  assign conv_fall = ~conv_lvl & conv_d;
  assign sck_rise  = sck_lvl & ~sck_d;
  assign sck_fall  = ~sck_lvl & sck_d;

  adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .conv_lvl(conv_lvl), .conv_rise(conv_rise),
    .conv_fall(conv_fall), .state_o(state), .done_o(done),
    .enter_sample_o(enter_sample)
  );

  adc_shift_io #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_io (
    .clk(clk), .rst(rst), .start_i(conv_rise), .load_i(done),
    .enter_sample_i(enter_sample), .in_sample_i(state == ST_SAMPLE),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sdi_lvl_i(sdi_lvl),
    .core_data_i(core_data_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .chan_pos_o(chan_pos_o), .chan_neg_o(chan_neg_o)
  );

  assign busy_o   = (state == ST_CONV);
  assign sleep_o  = (state == ST_SLEEP);
  assign sample_o = (state == ST_SAMPLE);
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 320
) (
  input logic       clk,
  input logic       rst,
  input logic       busy_o,
  input logic       sleep_o,
  input logic       sample_o,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input logic [1:0] chan_pos_o,
  input logic [1:0] chan_neg_o,
  input logic       sck_fall
);
  localparam int RUN_W  = $clog2(CONV_CYCLES + 2) + 1;
  localparam int FALL_W = $clog2(DATA_W + 2) + 1;

  logic [RUN_W-1:0]  busy_run;
  logic [FALL_W-1:0] fall_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_run <= '0;
    else if (busy_run != '1) busy_run <= busy_run + 1'b1;
    if (rst || !sample_o) fall_cnt <= '0;
    else if (sck_fall && fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
  end

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!sdo_oe_o && !sample_o && !sleep_o)); // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_run >= RUN_W'(CONV_CYCLES))); // R2
  AST_OE_IN_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> sample_o); // R4
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> !sdo_oe_o); // R3
  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (rst)
    (sample_o && fall_cnt >= FALL_W'(DATA_W)) |-> !sdo_o); // R6
  AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(chan_pos_o) && $onehot0(chan_neg_o) && ((chan_pos_o & chan_neg_o) == 2'b00)); // R8
  AST_SEL_AT_START: assert property (@(posedge clk) disable iff (rst)
    !($stable(chan_pos_o) && $stable(chan_neg_o)) |-> busy_o); // R8
endmodule

bind adc_serial_port adc_serial_port_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .sleep_o(sleep_o), .sample_o(sample_o),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .chan_pos_o(chan_pos_o),
  .chan_neg_o(chan_neg_o), .sck_fall(sck_fall)
);

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int C = 24;
  localparam int W = 12;

  logic clk = 0, rst = 1, conv = 0, sck = 0, sdi = 0;
  logic [W-1:0] core = '0;
  logic sdo, oe, busy, slp, smp;
  logic [1:0] cpos, cneg;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0] pend = 2'b10;

  always #5 clk = ~clk;

  adc_serial_port #(.CONV_CYCLES(C)) u_dut (
    .clk(clk), .rst(rst), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
    .core_data_i(core), .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy),
    .sleep_o(slp), .sample_o(smp), .chan_pos_o(cpos), .chan_neg_o(cneg)
  );

  function automatic logic [1:0] exp_pos(input logic [1:0] s);
    return s[0] ? 2'b10 : 2'b01;
  endfunction
  function automatic logic [1:0] exp_neg(input logic [1:0] s);
    return s[1] ? 2'b00 : (s[0] ? 2'b01 : 2'b10);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_conv(input logic [W-1:0] d);
    core = d;
    conv = 1;
    nw(3);
    chk("R2 busy early", busy, 1);
    chk("R9 oe off at restart", oe, 0);
    chk("R8 pos", cpos, exp_pos(pend));
    chk("R8 neg", cneg, exp_neg(pend));
    nw(C - 3);
    chk("R2 busy at C", busy, 1);
    nw(4);
    chk("R2 busy done", busy, 0);
    chk("R3 sleeping", slp, 1);
    chk("R4 oe low while conv high", oe, 0);
  endtask

  task automatic end_conv();
    conv = 0;
    nw(5);
    chk("R4 sampling", smp, 1);
    chk("R4 oe", oe, 1);
  endtask

  // n clocks; first two carry sel, rest carry junk
  task automatic xfer(input logic [W-1:0] d, input logic [1:0] sel, input int n,
                      input logic [7:0] junk);
    for (int i = 0; i < n; i++) begin
      chk(i < W ? "R5 data bit" : "R6 zero tail", sdo, (i < W) ? d[W-1-i] : 1'b0);
      sdi = (i < 2) ? sel[1-i] : junk[i % 8];
      nw(1);
      sck = 1;
      nw(4);
      sck = 0;
      nw(4);
    end
    if (n >= 2) pend = sel;
  endtask

  initial begin
    nw(3);
    rst = 0;
    nw(2);
    chk("R1 sleep", slp, 1);
    chk("R1 busy", busy, 0);
    chk("R1 sample", smp, 0);
    chk("R1 oe", oe, 0);
    chk("R1 pos", cpos, 2'b01);
    chk("R1 neg", cneg, 2'b00);

    // basic transfer, word 01, core changes after capture
    start_conv(12'hA5C);
    nw(40);
    chk("R3 still asleep", slp, 1);
    chk("R3 oe still low", oe, 0);
    end_conv();
    core = 12'h3C3;
    chk("R8 not yet applied", cpos, 2'b01);
    xfer(12'hA5C, 2'b01, W + 4, 8'hFF);   // R11 via changed core
    chk("R8 still old during transfer", cneg, 2'b00);

    // word 11 with later SDI ones/zeros that must be ignored (R7)
    start_conv(12'hFFF);
    end_conv();
    xfer(12'hFFF, 2'b11, W + 2, 8'h00);
    // one-clock transfer keeps pending 11 (R7)
    start_conv(12'h001);
    end_conv();
    xfer(12'h001, 2'b00, 1, 8'h00);
    // restart mid-transfer (R9)
    start_conv(12'h800);
    end_conv();
    xfer(12'h800, 2'b00, 5, 8'h55);
    start_conv(12'h6B2);
    end_conv();
    xfer(12'h6B2, 2'b10, W, 8'h00);

    // early fall: conversion ends with conv low (R10)
    core = 12'h9E7;
    conv = 1;
    nw(3);
    conv = 0;
    nw(C + 6);
    chk("R10 direct sample", smp, 1);
    chk("R10 oe", oe, 1);
    chk("R10 busy low", busy, 0);
    xfer(12'h9E7, 2'b01, W + 1, 8'hA5);

    // random transfers
    void'($urandom(32'h1357));
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] d;
      logic [1:0] s;
      d = W'($urandom);
      s = 2'($urandom);
      start_conv(d);
      end_conv();
      xfer(d, s, W + int'($urandom % 4), 8'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule